// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block models a byte-wide parallel flash device with a small on-chip array. It sits on a plain bus. One address serves both directions, a write strobe comes with a data byte, and a read strobe returns a byte one cycle later. The array powers up erased: every byte reads 0xFF.

Every write goes through a command sequencer. A command begins with a fixed pair of key writes. A third write at the command address then names the operation. The erase command opens a second key pair, and a sixth write selects the kind of erase. The available operations are:

- byte program;
- whole-array erase;
- 4 KiB sector erase;
- entering or leaving an identification mode, in which reads return fixed identity bytes instead of array data.

Program and erase hold a busy output high for a fixed number of cycles. The array changes only at the end of that window, and any write that arrives during the window is dropped.

The sequencer states are:

- `ST_IDLE`: waiting for a first key.
- `ST_KEY1`: first key seen.
- `ST_KEY2`: second key seen; awaiting the command byte.
- `ST_EXT0`: erase opened; awaiting the fourth write.
- `ST_EXT1`: fourth write seen; awaiting the fifth.
- `ST_EXT2`: awaiting the sixth write.
- `ST_ARMED`: the next write is programmed.

The transitions are:

- Key match: `ST_IDLE`→`ST_KEY1`→`ST_KEY2`, and `ST_EXT0`→`ST_EXT1`→`ST_EXT2`.
- Erase open: `ST_KEY2`→`ST_EXT0` on 0x80.
- Arm: `ST_KEY2`→`ST_ARMED` on 0xA0.
- Launch: `ST_ARMED`→`ST_IDLE`, and `ST_EXT2`→`ST_IDLE` on an erase code.
- Abort: any mismatch returns to `ST_IDLE`.
- Quick exit: `ST_IDLE`→`ST_IDLE` on a lone 0xF0, which clears identification mode.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, busy is low, identification mode is off, rd_data is 0xFF, and every array byte reads 0xFF.
- R2: A command begins with data 0xAA at an address whose low 15 bits are 0x5555, followed by 0x55 at low-15-bit address 0x2AAA. The third write carries the command byte and must also be at low-15-bit address 0x5555. Address bits 15 and up are not compared.
- R3: A write whose address or data differs from what the current key step expects returns the sequencer to idle, and that write has no effect.
- R4: Command 0xA0 arms programming. The next write stores its data byte at its address, taken modulo the array size, and the sequencer returns to idle.
- R5: Command 0x80 followed by 0xAA@0x5555, 0x55@0x2AAA and then 0x10@0x5555 erases the whole array to 0xFF.
- R6: In that same sixth position, data 0x30 at any address erases only the 4 KiB sector containing that address (address with its low 12 bits cleared). Other sectors keep their contents.
- R7: Command 0x90, or sixth-write data 0x60 at 0x5555, enters identification mode.
- R8: In identification mode a read at address 0 returns 0xBF, a read at address 1 returns the DEV_CODE parameter, and any other address returns 0xFF.
- R9: Command 0xF0 leaves identification mode. A lone 0xF0 write to any address while idle also leaves it.
- R10: Program and erase raise busy in the cycle after the launching write and keep it high for exactly OP_CYCLES cycles. The array holds its old value until busy falls.
- R11: Every write accepted while busy is high is ignored: sequencer state and identification mode are unchanged.
- R12: An unknown third-position or sixth-position command byte returns the sequencer to idle with no effect.
- R13: rd_data reflects the read addressed at a clock edge where rd_en is high, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | BUS_AW | Byte address for reads and writes |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| busy | output | 1 | High while a program or erase is in progress |

## Verification
The bench sends key writes with high address bits set. A design that compares the full address would then never unlock. It breaks a key pair with one wrong address bit and checks that a later program write leaves the array untouched. A sector erase is aimed at the upper sector, and the lower sector is read back afterwards, which catches an erase applied to the wrong region or to the whole array. The bench also reads during the busy window and sends a full identification command while busy. An early array update, or a sequencer that keeps listening while busy, would then show up in the returned bytes.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    localparam int KEY_AW = 15;

    localparam logic [KEY_AW-1:0] ADR_KEY_A = 15'h5555;
    localparam logic [KEY_AW-1:0] ADR_KEY_B = 15'h2AAA;

    localparam logic [7:0] DAT_KEY_A    = 8'hAA;
    localparam logic [7:0] DAT_KEY_B    = 8'h55;
    localparam logic [7:0] CMD_ERASE    = 8'h80;
    localparam logic [7:0] CMD_ID_ON    = 8'h90;
    localparam logic [7:0] CMD_PROG     = 8'hA0;
    localparam logic [7:0] CMD_ID_OFF   = 8'hF0;
    localparam logic [7:0] SUB_CHIP     = 8'h10;
    localparam logic [7:0] SUB_SECT     = 8'h30;
    localparam logic [7:0] SUB_ID_ON    = 8'h60;
    localparam logic [7:0] MFR_CODE     = 8'hBF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_KEY1,
        ST_KEY2,
        ST_EXT0,
        ST_EXT1,
        ST_EXT2,
        ST_ARMED
    } seq_state_t;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_PROG,
        OP_SECT,
        OP_CHIP
    } op_kind_t;

endpackage

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
    import flash_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [KEY_AW-1:0] key_addr,
    input  logic [7:0]        wr_data,
    input  logic              busy,
    output seq_state_t        state,
    output logic              id_mode,
    output logic              op_start,
    output op_kind_t          op_kind
);

    seq_state_t state_nxt;
    logic       id_nxt;
    logic       take;
    logic       at_a;
    logic       at_b;

    assign take = wr_en && !busy;
    assign at_a = (key_addr == ADR_KEY_A);
    assign at_b = (key_addr == ADR_KEY_B);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            id_mode <= 1'b0;
        end else begin
            state   <= state_nxt;
            id_mode <= id_nxt;
        end
    end

    // next state and outputs
    always_comb begin
        state_nxt = state;
        id_nxt    = id_mode;
        op_start  = 1'b0;
        op_kind   = OP_NONE;
        if (take) begin
            unique case (state)
                ST_IDLE: begin
                    if (at_a && wr_data == DAT_KEY_A)
                        state_nxt = ST_KEY1;
                    else if (wr_data == CMD_ID_OFF)
                        id_nxt = 1'b0;
                end
                ST_KEY1: begin
                    state_nxt = (at_b && wr_data == DAT_KEY_B) ? ST_KEY2 : ST_IDLE;
                end
                ST_KEY2: begin
                    state_nxt = ST_IDLE;
                    if (at_a) begin
                        case (wr_data)
                            CMD_ERASE:  state_nxt = ST_EXT0;
                            CMD_PROG:   state_nxt = ST_ARMED;
                            CMD_ID_ON:  id_nxt = 1'b1;
                            CMD_ID_OFF: id_nxt = 1'b0;
                            default:    state_nxt = ST_IDLE;
                        endcase
                    end
                end
                ST_EXT0: begin
                    state_nxt = (at_a && wr_data == DAT_KEY_A) ? ST_EXT1 : ST_IDLE;
                end
                ST_EXT1: begin
                    state_nxt = (at_b && wr_data == DAT_KEY_B) ? ST_EXT2 : ST_IDLE;
                end
                ST_EXT2: begin
                    state_nxt = ST_IDLE;
                    if (wr_data == SUB_SECT) begin
                        op_start = 1'b1;
                        op_kind  = OP_SECT;
                    end else if (at_a && wr_data == SUB_CHIP) begin
                        op_start = 1'b1;
                        op_kind  = OP_CHIP;
                    end else if (at_a && wr_data == SUB_ID_ON) begin
                        id_nxt = 1'b1;
                    end
                end
                ST_ARMED: begin
                    state_nxt = ST_IDLE;
                    op_start  = 1'b1;
                    op_kind   = OP_PROG;
                end
                default: state_nxt = ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/flash_op_timer.sv
module flash_op_timer
    import flash_seq_pkg::*;
#(
    parameter int ARR_AW    = 13,
    parameter int OP_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_start,
    input  op_kind_t          op_kind,
    input  logic [ARR_AW-1:0] op_addr,
    input  logic [7:0]        op_data,
    output logic              busy,
    output logic              commit,
    output op_kind_t          cmt_kind,
    output logic [ARR_AW-1:0] cmt_addr,
    output logic [7:0]        cmt_data
);

    localparam int CNT_W = (OP_CYCLES > 1) ? $clog2(OP_CYCLES) : 1;

    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            remain   <= '0;
            cmt_kind <= OP_NONE;
            cmt_addr <= '0;
            cmt_data <= 8'hFF;
        end else if (op_start && !busy) begin
            busy     <= 1'b1;
            remain   <= CNT_W'(OP_CYCLES - 1);
            cmt_kind <= op_kind;
            cmt_addr <= op_addr;
            cmt_data <= op_data;
        end else if (busy) begin
            if (remain == '0)
                busy <= 1'b0;
            else
                remain <= remain - 1'b1;
        end
    end

    assign commit = busy && (remain == '0);

endmodule

// File: rtl/flash_store.sv
module flash_store
    import flash_seq_pkg::*;
#(
    parameter int         BUS_AW   = 16,
    parameter int         ARR_AW   = 13,
    parameter int         SECT_AW  = 12,
    parameter logic [7:0] DEV_CODE = 8'hB5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  op_kind_t          cmt_kind,
    input  logic [ARR_AW-1:0] cmt_addr,
    input  logic [7:0]        cmt_data,
    input  logic              rd_en,
    input  logic [BUS_AW-1:0] rd_addr,
    input  logic              id_mode,
    output logic [7:0]        rd_data
);

    localparam int DEPTH = 1 << ARR_AW;
    localparam int SEC_W = ARR_AW - SECT_AW;

    logic [7:0]       mem [DEPTH];
    logic [DEPTH-1:0] wipe;
    logic [DEPTH-1:0] poke;
    logic [7:0]       id_byte;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            wipe[i] = (cmt_kind == OP_CHIP) ||
                      ((cmt_kind == OP_SECT) &&
                       (SEC_W'(i >> SECT_AW) == cmt_addr[ARR_AW-1:SECT_AW]));
            poke[i] = (cmt_kind == OP_PROG) && (ARR_AW'(i) == cmt_addr);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= 8'hFF;
        end else if (commit) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (wipe[i])
                    mem[i] <= 8'hFF;
                else if (poke[i])
                    mem[i] <= cmt_data;
            end
        end
    end

    always_comb begin
        if (rd_addr == BUS_AW'(0))
            id_byte = MFR_CODE;
        else if (rd_addr == BUS_AW'(1))
            id_byte = DEV_CODE;
        else
            id_byte = 8'hFF;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rd_data <= 8'hFF;
        else if (rd_en)
            rd_data <= id_mode ? id_byte : mem[rd_addr[ARR_AW-1:0]];
    end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_seq_pkg::*;
#(
    parameter int         BUS_AW    = 16,
    parameter int         ARR_AW    = 13,
    parameter int         SECT_AW   = 12,
    parameter int         OP_CYCLES = 4,
    parameter logic [7:0] DEV_CODE  = 8'hB5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_AW-1:0] addr,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    input  logic              rd_en,
    output logic [7:0]        rd_data,
    output logic              busy
);

    seq_state_t        seq_state;
    logic              id_mode;
    logic              op_start;
    op_kind_t          op_kind;
    logic              commit;
    op_kind_t          cmt_kind;
    logic [ARR_AW-1:0] cmt_addr;
    logic [7:0]        cmt_data;

    flash_seq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .key_addr (addr[KEY_AW-1:0]),
        .wr_data  (wr_data),
        .busy     (busy),
        .state    (seq_state),
        .id_mode  (id_mode),
        .op_start (op_start),
        .op_kind  (op_kind)
    );

    flash_op_timer #(
        .ARR_AW    (ARR_AW),
        .OP_CYCLES (OP_CYCLES)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_start (op_start),
        .op_kind  (op_kind),
        .op_addr  (addr[ARR_AW-1:0]),
        .op_data  (wr_data),
        .busy     (busy),
        .commit   (commit),
        .cmt_kind (cmt_kind),
        .cmt_addr (cmt_addr),
        .cmt_data (cmt_data)
    );

    flash_store #(
        .BUS_AW   (BUS_AW),
        .ARR_AW   (ARR_AW),
        .SECT_AW  (SECT_AW),
        .DEV_CODE (DEV_CODE)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (commit),
        .cmt_kind (cmt_kind),
        .cmt_addr (cmt_addr),
        .cmt_data (cmt_data),
        .rd_en    (rd_en),
        .rd_addr  (addr),
        .id_mode  (id_mode),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk
    import flash_seq_pkg::*;
#(
    parameter int         BUS_AW    = 16,
    parameter int         OP_CYCLES = 4,
    parameter logic [7:0] DEV_CODE  = 8'hB5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [BUS_AW-1:0] addr,
    input logic              wr_en,
    input logic [7:0]        wr_data,
    input logic              rd_en,
    input logic [7:0]        rd_data,
    input logic              busy,
    input seq_state_t        seq_state,
    input logic              id_mode,
    input logic              op_start
);

    int unsigned run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            run_len <= 0;
        else if (busy)
            run_len <= run_len + 1;
        else
            run_len <= 0;
    end

    p_busy_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |=> busy);

    p_busy_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_len < OP_CYCLES));

    p_busy_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en) |=> ($stable(seq_state) && $stable(id_mode)));

    p_abort_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !busy && seq_state == ST_KEY1 &&
         !(addr[KEY_AW-1:0] == ADR_KEY_B && wr_data == DAT_KEY_B))
        |=> (seq_state == ST_IDLE));

    p_lone_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !busy && seq_state == ST_IDLE && wr_data == CMD_ID_OFF)
        |=> !id_mode);

    p_id_mfr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && id_mode && addr == BUS_AW'(0)) |=> (rd_data == MFR_CODE));

    p_id_dev_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && id_mode && addr == BUS_AW'(1)) |=> (rd_data == DEV_CODE));

    p_rd_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(
    .BUS_AW    (BUS_AW),
    .OP_CYCLES (OP_CYCLES),
    .DEV_CODE  (DEV_CODE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .busy      (busy),
    .seq_state (seq_state),
    .id_mode   (id_mode),
    .op_start  (op_start)
);

// File: tb/flash_cmd_seq_test.sv
module flash_cmd_seq_test;

    localparam int         OPC  = 4;
    localparam logic [7:0] DEV  = 8'hB5;
    localparam int         NVEC = 61;

    // entry: {kind[1:0], addr[15:0], data[7:0], req[3:0]}
    // kind 0 = write, 1 = read and compare with data, 2 = wait for busy low
    localparam logic [29:0] VEC [NVEC] = '{
        // R4 basic program
        {2'd0, 16'h5555, 8'hAA, 4'd4}, {2'd0, 16'h2AAA, 8'h55, 4'd4},
        {2'd0, 16'h5555, 8'hA0, 4'd4}, {2'd0, 16'h0010, 8'h3C, 4'd4},
        {2'd2, 16'h0000, 8'h00, 4'd4}, {2'd1, 16'h0010, 8'h3C, 4'd4},
        // R2 high address bits ignored, R4 modulo array size
        {2'd0, 16'hD555, 8'hAA, 4'd2}, {2'd0, 16'hAAAA, 8'h55, 4'd2},
        {2'd0, 16'h5555, 8'hA0, 4'd2}, {2'd0, 16'h3021, 8'h5A, 4'd2},
        {2'd2, 16'h0000, 8'h00, 4'd2}, {2'd1, 16'h1021, 8'h5A, 4'd2},
        // R3 broken key pair
        {2'd0, 16'h5555, 8'hAA, 4'd3}, {2'd0, 16'h2AAB, 8'h55, 4'd3},
        {2'd0, 16'h5555, 8'hA0, 4'd3}, {2'd0, 16'h0020, 8'h77, 4'd3},
        {2'd1, 16'h0020, 8'hFF, 4'd3},
        // R7 / R8 identification via 0x90
        {2'd0, 16'h5555, 8'hAA, 4'd7}, {2'd0, 16'h2AAA, 8'h55, 4'd7},
        {2'd0, 16'h5555, 8'h90, 4'd7}, {2'd1, 16'h0000, 8'hBF, 4'd8},
        {2'd1, 16'h0001, DEV,   4'd8}, {2'd1, 16'h0002, 8'hFF, 4'd8},
        // R9 lone exit
        {2'd0, 16'h1234, 8'hF0, 4'd9}, {2'd1, 16'h0010, 8'h3C, 4'd9},
        // R7 identification via sixth write 0x60
        {2'd0, 16'h5555, 8'hAA, 4'd7}, {2'd0, 16'h2AAA, 8'h55, 4'd7},
        {2'd0, 16'h5555, 8'h80, 4'd7}, {2'd0, 16'h5555, 8'hAA, 4'd7},
        {2'd0, 16'h2AAA, 8'h55, 4'd7}, {2'd0, 16'h5555, 8'h60, 4'd7},
        {2'd1, 16'h0000, 8'hBF, 4'd7},
        // R9 exit by command
        {2'd0, 16'h5555, 8'hAA, 4'd9}, {2'd0, 16'h2AAA, 8'h55, 4'd9},
        {2'd0, 16'h5555, 8'hF0, 4'd9}, {2'd1, 16'h0010, 8'h3C, 4'd9},
        // R12 unknown third command
        {2'd0, 16'h5555, 8'hAA, 4'd12}, {2'd0, 16'h2AAA, 8'h55, 4'd12},
        {2'd0, 16'h5555, 8'h77, 4'd12}, {2'd0, 16'h0030, 8'h12, 4'd12},
        {2'd1, 16'h0030, 8'hFF, 4'd12},
        // R12 unknown sixth command
        {2'd0, 16'h5555, 8'hAA, 4'd12}, {2'd0, 16'h2AAA, 8'h55, 4'd12},
        {2'd0, 16'h5555, 8'h80, 4'd12}, {2'd0, 16'h5555, 8'hAA, 4'd12},
        {2'd0, 16'h2AAA, 8'h55, 4'd12}, {2'd0, 16'h5555, 8'h50, 4'd12},
        {2'd1, 16'h0010, 8'h3C, 4'd12},
        // R6 sector erase of upper sector only
        {2'd0, 16'h5555, 8'hAA, 4'd6}, {2'd0, 16'h2AAA, 8'h55, 4'd6},
        {2'd0, 16'h5555, 8'h80, 4'd6}, {2'd0, 16'h5555, 8'hAA, 4'd6},
        {2'd0, 16'h2AAA, 8'h55, 4'd6}, {2'd0, 16'h1ABC, 8'h30, 4'd6},
        {2'd2, 16'h0000, 8'h00, 4'd6}, {2'd1, 16'h1021, 8'hFF, 4'd6},
        {2'd1, 16'h0010, 8'h3C, 4'd6},
        // R5 chip erase (setup, final read done after the loop)
        {2'd0, 16'h5555, 8'hAA, 4'd5}, {2'd0, 16'h2AAA, 8'h55, 4'd5},
        {2'd0, 16'h5555, 8'h80, 4'd5}, {2'd0, 16'h5555, 8'hAA, 4'd5}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_data;
    logic        busy;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    flash_cmd_seq #(
        .BUS_AW    (16),
        .ARR_AW    (13),
        .SECT_AW   (12),
        .OP_CYCLES (OPC),
        .DEV_CODE  (DEV)
    ) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_data (rd_data),
        .busy    (busy)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        addr    = a;
        wr_data = d;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] v);
        addr  = a;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        v     = rd_data;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic finish_up();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_up();
    end

    initial begin
        logic [7:0] v;
        int         n;
        string      tag;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 busy", 32'(busy), 32'd0);
        check("R1 rd_data", 32'(rd_data), 32'hFF);
        rd(16'h1FFF, v);
        check("R1 array", 32'(v), 32'hFF);

        for (int k = 0; k < NVEC; k++) begin
            tag = $sformatf("R%0d vec%0d", VEC[k][3:0], k);
            unique case (VEC[k][29:28])
                2'd0: wr(VEC[k][27:12], VEC[k][11:4]);
                2'd1: begin
                    rd(VEC[k][27:12], v);
                    check(tag, 32'(v), 32'(VEC[k][11:4]));
                end
                default: wait_idle();
            endcase
        end

        // R5 finish chip erase
        wr(16'h2AAA, 8'h55);
        wr(16'h5555, 8'h10);
        wait_idle();
        rd(16'h0010, v);
        check("R5 chip erase low", 32'(v), 32'hFF);
        rd(16'h1ABC, v);
        check("R5 chip erase high", 32'(v), 32'hFF);

        // R10 busy window length
        wr(16'h5555, 8'hAA);
        wr(16'h2AAA, 8'h55);
        wr(16'h5555, 8'hA0);
        wr(16'h0040, 8'h22);
        n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
        check("R10 busy cycles", 32'(n), 32'(OPC));
        rd(16'h0040, v);
        check("R10 programmed", 32'(v), 32'h22);

        // R10 array unchanged mid-operation
        wr(16'h5555, 8'hAA);
        wr(16'h2AAA, 8'h55);
        wr(16'h5555, 8'hA0);
        wr(16'h0050, 8'h33);
        rd(16'h0050, v);
        check("R10 old value while busy", 32'(v), 32'hFF);
        wait_idle();
        rd(16'h0050, v);
        check("R10 new value after busy", 32'(v), 32'h33);

        // R11 identification command during busy is dropped
        wr(16'h5555, 8'hAA);
        wr(16'h2AAA, 8'h55);
        wr(16'h5555, 8'hA0);
        wr(16'h0000, 8'h11);
        wr(16'h5555, 8'hAA);
        wr(16'h2AAA, 8'h55);
        wr(16'h5555, 8'h90);
        wait_idle();
        rd(16'h0000, v);
        check("R11 id not entered", 32'(v), 32'h11);

        // R13 read latency and hold
        addr  = 16'h0040;
        rd_en = 1'b1;
        #1;
        check("R13 before edge", 32'(rd_data), 32'h11);
        @(negedge clk);
        rd_en = 1'b0;
        check("R13 after edge", 32'(rd_data), 32'h22);
        addr = 16'h0050;
        @(negedge clk);
        check("R13 hold", 32'(rd_data), 32'h22);

        finish_up();
    end

endmodule